// File: doc/BRIEF.md
# Shared DRAM Address Multiplexer

This block lets a processor and a display controller share one DRAM array without any arbitration. Time is cut into half-periods of the 2 MHz system clock. The processor owns the array in one half-period and the display controller owns it in the other. Neither side ever waits for the other, and because the display scan sweeps the whole array over and over, it also refreshes it. No separate refresh cycle exists.

In each half-period the block takes the owner's 16-bit address and sends it to the array over 8 address pins. The low byte goes out first and RAS latches it. The high byte follows and CAS latches it. Then both strobes are released. The four steps are paced by a step enable at four times the phase rate. The levels of the 8, 4 and 2 MHz clocks, sampled on that enable, give the step number and the owner. The display controller's address is folded back into the screen region when it runs past the top of memory. A 2-bit screen-size code sets the region size.

Top module: `dmx_dram_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to `ma`=0, `ras_n`=1, `cas_n`=1, `we_n`=1 and `disp_owner`=0.
- R2: The step number is {`clk4_lvl`,`clk8_lvl`}, sampled on `step_tick`. On a step-0 tick, `ma` takes the low byte of the selected address and `ras_n` goes low with `cas_n` high. `disp_owner` takes `clk2_lvl`.
- R3: On a step-1 tick, `ma` takes the high byte and RAS stays asserted. On a step-2 tick, `cas_n` goes low and `ma` is unchanged. On a step-3 tick, `ras_n` and `cas_n` both return high. `ma` is held through step 3.
- R4: `clk2_lvl`=0 at the step-0 tick selects `cpu_addr` (processor phase). `clk2_lvl`=1 selects the mapped `disp_addr` (display phase). Every phase of either kind performs one full RAS/CAS cycle, and no other refresh is issued.
- R5: `we_n` goes low at the step-0 tick only if it is a processor phase and `cpu_wr`=1. It stays low through step 2, so it is already low when CAS falls, and it returns high at step 3. In a display phase `we_n` stays high whatever `cpu_wr` is.
- R6: The selected address is captured at the step-0 tick. Changes to `cpu_addr`, `disp_addr`, `scr_code` or `cpu_wr` after that tick do not affect the column byte or `we_n` of the same phase.
- R7: A display address with bit 15 clear is sent to the array unchanged.
- R8: A display address with bit 15 set is wrapped by subtracting the screen size, modulo 2^16. Screen size by `scr_code`: 0 = 20 KB (0x5000), 1 = 16 KB (0x4000), 2 = 10 KB (0x2800), 3 = 8 KB (0x2000).
- R9: Without `step_tick`, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_tick | input | 1 | One-cycle step enable, four per half-period |
| clk2_lvl | input | 1 | 2 MHz clock level: 0 processor phase, 1 display phase |
| clk4_lvl | input | 1 | 4 MHz clock level, step number bit 1 |
| clk8_lvl | input | 1 | 8 MHz clock level, step number bit 0 |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wr | input | 1 | Processor write request |
| disp_addr | input | 16 | Raw display controller address |
| scr_code | input | 2 | Screen-size code |
| ma | output | 8 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| disp_owner | output | 1 | Current cycle belongs to the display side |

## Verification
A wrong captured owner or address shows up on `ma` one step after the step-0 tick. A fault in the high-byte hold shows up on the following tick. A sequencer fault shows up at once as a strobe in the wrong step, for example CAS without RAS, or write enable during a display phase. A wrong wrap size only shows in display phases whose address has bit 15 set. For that reason the bench runs every screen code across the wrap boundary and also changes inputs in the middle of a phase.

// File: rtl/dmx_pkg.sv
// Package: shared types and the screen-size table for the DRAM multiplexer.
// Assumes a 2-bit screen-size code and sizes given in kilobytes.
package dmx_pkg;

    // Step positions within one half-period of the system clock
    typedef enum logic [1:0] {
        STEP_ROW    = 2'd0,
        STEP_COL    = 2'd1,
        STEP_STROBE = 2'd2,
        STEP_REL    = 2'd3
    } step_e;

    // Owner of the array in the current half-period
    typedef enum logic {
        OWN_CPU  = 1'b0,
        OWN_DISP = 1'b1
    } owner_e;

    localparam int unsigned KB_SHIFT = 10;

    // Screen region size in kilobytes for each size code
    function automatic int unsigned scr_kbytes(input logic [1:0] code);
        case (code)
            2'd0:    return 20;
            2'd1:    return 16;
            2'd2:    return 10;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/dmx_scr_wrap.sv
// Display address wrap: an address that has passed the top of memory
// (top bit set) is folded back by the screen size chosen by the code.
// Assumes the screen region ends at the top of the address space.
module dmx_scr_wrap
    import dmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] raw_addr,
    input  logic [1:0]    code,
    output logic [AW-1:0] mapped_addr
);
    logic [AW-1:0] size_w;
    logic [AW-1:0] neg_size;

    // Screen size in bytes and its two's complement for the fold-back add
    always_comb begin
        size_w   = AW'(scr_kbytes(code)) << KB_SHIFT;
        neg_size = ~size_w + AW'(1);
    end

    // Fold addresses above the top back into the screen region
    always_comb begin
        if (raw_addr[AW-1]) mapped_addr = raw_addr + neg_size;
        else                mapped_addr = raw_addr;
    end
endmodule

// File: rtl/dmx_step_seq.sv
// Strobe sequencer: produces RAS, CAS and WE for one RAS/CAS cycle per
// half-period, advancing only on the step enable.
// Assumes the step number arrives in order 0..3 within each half-period.
module dmx_step_seq
    import dmx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  step_e  step,
    input  owner_e owner,
    input  logic   wr_req,
    output logic   ras_n,
    output logic   cas_n,
    output logic   we_n
);
    logic wr_phase;

    // A write is allowed only when the processor owns the array
    always_comb wr_phase = (owner == OWN_CPU) && wr_req;

    // Strobe registers, advanced once per step enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
        end else if (tick) begin
            case (step)
                STEP_ROW: begin
                    ras_n <= 1'b0;
                    cas_n <= 1'b1;
                    we_n  <= !wr_phase;
                end
                STEP_COL: begin
                    ras_n <= 1'b0;
                    cas_n <= 1'b1;
                end
                STEP_STROBE: begin
                    ras_n <= 1'b0;
                    cas_n <= 1'b0;
                end
                default: begin
                    ras_n <= 1'b1;
                    cas_n <= 1'b1;
                    we_n  <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/dmx_addr_path.sv
// Address path: picks the owner's address at the row step, drives the
// low half on the pins, keeps the high half for the column step.
// Assumes AW is even so that row and column are the same width.
module dmx_addr_path
    import dmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  step_e           step,
    input  owner_e          owner,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [AW-1:0]   disp_mapped,
    output logic [AW/2-1:0] ma,
    output logic            disp_owner
);
    localparam int MW = AW / 2;

    logic [AW-1:0] sel_addr;
    logic [MW-1:0] hi_q;

    // Owner select between processor and mapped display address
    always_comb sel_addr = (owner == OWN_DISP) ? disp_mapped : cpu_addr;

    // Pin driver and column hold, updated only on the step enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ma         <= '0;
            hi_q       <= '0;
            disp_owner <= 1'b0;
        end else if (tick) begin
            case (step)
                STEP_ROW: begin
                    ma         <= sel_addr[MW-1:0];
                    hi_q       <= sel_addr[AW-1:MW];
                    disp_owner <= (owner == OWN_DISP);
                end
                STEP_COL: ma <= hi_q;
                default:  ma <= ma;
            endcase
        end
    end
endmodule

// File: rtl/dmx_dram_mux.sv
// Top: shared DRAM address multiplexer. The processor and the display
// controller own the array on alternate system-clock phases; each phase
// runs one RAS/CAS cycle whose step number comes from the 8/4 MHz levels.
// Assumes the step enable pulses once per step and inputs are synchronous.
module dmx_dram_mux
    import dmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_tick,
    input  logic            clk2_lvl,
    input  logic            clk4_lvl,
    input  logic            clk8_lvl,
    input  logic [AW-1:0]   cpu_addr,
    input  logic            cpu_wr,
    input  logic [AW-1:0]   disp_addr,
    input  logic [1:0]      scr_code,
    output logic [AW/2-1:0] ma,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic            disp_owner
);
    step_e         step;
    owner_e        owner;
    logic [AW-1:0] disp_mapped;

    // Decode step number and owner from the clock levels
    always_comb begin
        step  = step_e'({clk4_lvl, clk8_lvl});
        owner = owner_e'(clk2_lvl);
    end

    dmx_scr_wrap #(.AW(AW)) wrap_i (
        .raw_addr    (disp_addr),
        .code        (scr_code),
        .mapped_addr (disp_mapped)
    );

    dmx_addr_path #(.AW(AW)) path_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (step_tick),
        .step        (step),
        .owner       (owner),
        .cpu_addr    (cpu_addr),
        .disp_mapped (disp_mapped),
        .ma          (ma),
        .disp_owner  (disp_owner)
    );

    dmx_step_seq seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (step_tick),
        .step   (step),
        .owner  (owner),
        .wr_req (cpu_wr),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n)
    );
endmodule

// File: rtl/dmx_dram_mux_chk.sv
// Checker: protocol properties of the strobe and address outputs.
// Assumes it is bound to every instance of the top module.
module dmx_dram_mux_chk #(
    parameter int AW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_tick,
    input logic [AW/2-1:0] ma,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            disp_owner
);
    // R3: CAS is only active while RAS is active
    a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R3: CAS falls only after RAS was already low
    a_r3_ras_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

    // R3: the column address stays on the pins while CAS is asserted
    a_r3_ma_stable_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(ma));

    // R5: write enable never asserted in a display phase
    a_r5_we_cpu_only: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !disp_owner);

    // R5: write enable already low when CAS falls in a write cycle
    a_r5_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> $past(!we_n));

    // R9: outputs hold when no step enable was seen
    a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_tick)) |->
        ($stable(ma) && $stable(ras_n) && $stable(cas_n) && $stable(we_n)));
endmodule

bind dmx_dram_mux dmx_dram_mux_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_tick  (step_tick),
    .ma         (ma),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .disp_owner (disp_owner)
);

// File: tb/dmx_dram_mux_tb.sv
// Scoreboard bench: the driver pushes the expected pin state for each
// step; a monitor pops and compares it once the design has updated.
module dmx_dram_mux_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_tick = 1'b0;
    logic        clk2_lvl = 1'b0;
    logic        clk4_lvl = 1'b0;
    logic        clk8_lvl = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [15:0] disp_addr = '0;
    logic [1:0]  scr_code = '0;
    logic [7:0]  ma;
    logic        ras_n, cas_n, we_n, disp_owner;

    int checks = 0;
    int fails  = 0;
    logic tick_seen = 1'b0;

    // Expected item: {ma, ras_n, cas_n, we_n, disp_owner}
    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    dmx_dram_mux dut_i (
        .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
        .clk2_lvl(clk2_lvl), .clk4_lvl(clk4_lvl), .clk8_lvl(clk8_lvl),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .disp_addr(disp_addr),
        .scr_code(scr_code), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .disp_owner(disp_owner)
    );

    function automatic logic [15:0] model_map(input logic [15:0] a, input logic [1:0] c);
        logic [15:0] sz;
        case (c)
            2'd0: sz = 16'h5000;
            2'd1: sz = 16'h4000;
            2'd2: sz = 16'h2800;
            default: sz = 16'h2000;
        endcase
        return a[15] ? a - sz : a;
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) tick_seen <= step_tick;

    // Monitor: compare outputs after each step enable
    always @(negedge clk) begin
        if (tick_seen) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 actual=unexpected-update expected=none");
            end else begin
                automatic logic [11:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, {ma, ras_n, cas_n, we_n, disp_owner}, e);
            end
        end
    end

    task automatic do_step(input logic [1:0] s, input logic own,
                           input logic [11:0] e, input string req);
        @(negedge clk);
        clk2_lvl = own;
        {clk4_lvl, clk8_lvl} = s;
        exp_q.push_back(e);
        tag_q.push_back(req);
        step_tick = 1'b1;
        @(negedge clk);
        step_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One half-period; scramble changes inputs after the row step (R6)
    task automatic run_phase(input logic own, input logic [15:0] ca, input logic wr,
                             input logic [15:0] da, input logic [1:0] code,
                             input logic scramble, input string req);
        logic [15:0] sel;
        logic        w;
        @(negedge clk);
        cpu_addr = ca; cpu_wr = wr; disp_addr = da; scr_code = code;
        sel = own ? model_map(da, code) : ca;
        w   = !(!own && wr);
        do_step(2'd0, own, {sel[7:0], 1'b0, 1'b1, w, own}, {req, " R2 row"});
        if (scramble) begin
            cpu_addr = ~ca; disp_addr = ~da; scr_code = code + 2'd1; cpu_wr = !wr;
        end
        do_step(2'd1, own, {sel[15:8], 1'b0, 1'b1, w, own}, {req, " R3 col"});
        do_step(2'd2, own, {sel[15:8], 1'b0, 1'b0, w, own}, {req, " R3 cas"});
        do_step(2'd3, own, {sel[15:8], 1'b1, 1'b1, 1'b1, own}, {req, " R3 release"});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset", {ma, ras_n, cas_n, we_n, disp_owner}, {8'h00, 1'b1, 1'b1, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        // R4 processor read and R5 processor write
        run_phase(1'b0, 16'h1234, 1'b0, 16'h4000, 2'd1, 1'b0, "R4 cpu read");
        run_phase(1'b0, 16'hA5C3, 1'b1, 16'h4000, 2'd1, 1'b0, "R5 cpu write");
        // R5 write request ignored in display phase; R7 unwrapped display
        run_phase(1'b1, 16'h0000, 1'b1, 16'h7F01, 2'd0, 1'b0, "R5 R7 disp ignore wr");
        run_phase(1'b1, 16'hFFFF, 1'b0, 16'h3000, 2'd3, 1'b0, "R7 disp low");
        // R8 wrap for every screen code, at and beyond the top
        for (int c = 0; c < 4; c++) begin
            run_phase(1'b1, 16'h0000, 1'b0, 16'h8000, c[1:0], 1'b0, "R8 wrap top");
            run_phase(1'b1, 16'h0000, 1'b0, 16'h8F21, c[1:0], 1'b0, "R8 wrap past");
        end
        // R6 inputs changed after the row step
        run_phase(1'b0, 16'h5A0F, 1'b1, 16'h1111, 2'd2, 1'b1, "R6 cpu latch");
        run_phase(1'b1, 16'h2222, 1'b0, 16'h9ABC, 2'd2, 1'b1, "R6 disp latch");
        // R4 alternating phases, display scan doubles as refresh
        for (int i = 0; i < 4; i++) begin
            run_phase(1'b0, 16'h0100 * i + 16'h0042, i[0], 16'h0000, 2'd1, 1'b0, "R4 alt cpu");
            run_phase(1'b1, 16'h0000, 1'b1, 16'h5800 + 16'h0008 * i, 2'd1, 1'b0, "R4 alt disp");
        end
        // R9 no tick: outputs hold with inputs changing
        @(negedge clk);
        cpu_addr = 16'hFFFF; disp_addr = 16'hFFFF; cpu_wr = 1'b1; clk2_lvl = 1'b0;
        {clk4_lvl, clk8_lvl} = 2'd0;
        repeat (10) @(negedge clk);
        check("R9 hold", {ma, ras_n, cas_n, we_n, disp_owner}, {8'h58, 1'b1, 1'b1, 1'b1, 1'b1});
        // R1 reset again mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset again", {ma, ras_n, cas_n, we_n, disp_owner}, {8'h00, 1'b1, 1'b1, 1'b1, 1'b0});
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R9 actual=%0d expected=0 pending items", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule